// File: doc/BRIEF.md
# Sequenced Register-File ALU Core

This block is a small programmable datapath with no control flow. A program counter walks through an on-chip instruction store one word per clock. Each 13-bit word names an ALU operation, two source registers and a destination register in an eight-entry register file. On every rising edge outside reset, the operation is applied to the two operands, the result is written to the destination, and the counter moves to the next address. After the last address the counter wraps back to the first.

The program is placed in the instruction store through a simple write port before execution starts, normally while reset is held. Execution begins at address zero. A set of observation outputs shows the current address, the current word, and the register write that the coming edge will perform. A surrounding environment can use them to compare every cycle against a model.

Top module: `seq_alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and all eight registers are cleared to zero. After release, every register reads as 0 until it is written.
- R2: The instruction word is laid out as bits [12:10] = second source index, [9:7] = first source index, [6:3] = operation code, [2:0] = destination index. A write always goes to the register named in bits [2:0].
- R3: On each rising edge with `rst` low, the program counter advances by exactly one. `dbg_instr` always shows the stored word at `dbg_pc`.
- R4: The program counter wraps from the last address (1023 by default) to 0 and keeps executing.
- R5: Arithmetic operations wrap modulo 2^DATA_W: code 0000 writes A+B, 0001 writes A-B, 0111 writes A+1 and 1000 writes A-1, where A and B are the first and second source values.
- R6: Logic operations: code 0010 writes A AND B, 0011 writes A OR B, 0100 writes A XOR B, and 0101 writes the bitwise inverse of A.
- R7: Code 0110 copies A unchanged into the destination.
- R8: Codes 1001 through 1111 write no register. `dbg_wr_en` is low for them, and the named destination keeps its value.
- R9: A register written by one instruction supplies the new value to the very next instruction that reads it.
- R10: While `rst` is high, `dbg_wr_en` is low and the program counter stays at 0. Words written through the load port during reset are the ones executed afterwards.
- R11: For codes 0101, 0110, 0111 and 1000, the second source field has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | ADDR_W | Instruction store write address |
| prog_data | input | 13 | Instruction word to store |
| dbg_pc | output | ADDR_W | Current program counter |
| dbg_instr | output | 13 | Word at the current program counter |
| dbg_wr_en | output | 1 | Register write performed at the next edge |
| dbg_wr_idx | output | 3 | Destination register of that write |
| dbg_wr_data | output | DATA_W | Value of that write |

## Verification
A directed opening sequence builds operands from zeroed registers with increments and decrements. This separates correct wraparound (0 minus 1 gives 0xFF, borrow on subtraction) from truncation errors, and chains each result into the next instruction to catch a write that lands one cycle late. Unused codes are followed by a copy out of the destination they named, which shows whether they wrote. Single-operand codes are repeated with different values in the ignored field. The rest of the 1024-word store holds a pseudo-random program that runs past the end of the store, so the counter wrap is checked. A second reset in the middle of the run, with a word rewritten while reset is held, checks that registers are cleared and that newly loaded code is fetched.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

  localparam int IDX_W   = 3;
  localparam int OP_W    = 4;
  localparam int INSTR_W = 3 * IDX_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'b0000,
    OP_SUB = 4'b0001,
    OP_AND = 4'b0010,
    OP_OR  = 4'b0011,
    OP_XOR = 4'b0100,
    OP_NOT = 4'b0101,
    OP_MOV = 4'b0110,
    OP_INC = 4'b0111,
    OP_DEC = 4'b1000
  } alu_op_e;

  // Layout is fixed: the decoder depends on this order (MSB first).
  typedef struct packed {
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] src_a;
    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] dst;
  } instr_t;

endpackage

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] pc
);

  // Natural wrap at 2**ADDR_W - 1 back to zero.
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + 1'b1;
  end

endmodule

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Asynchronous read: the word at the current address is visible in the
  // same cycle, as distributed memory.
  assign rdata = store[raddr];

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int N_RD   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [N_RD-1:0][IDX_W-1:0]  raddr,
  output logic [N_RD-1:0][DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  generate
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rdata[p] = regs[raddr[p]];
    end
  endgenerate

endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              valid
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    result = '0;
    valid  = 1'b1;
    case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_NOT:  result = ~a;
      OP_MOV:  result = a;
      OP_INC:  result = a + ONE;
      OP_DEC:  result = a - ONE;
      default: valid  = 1'b0;
    endcase
  end

endmodule

// File: rtl/seq_alu_core.sv
module seq_alu_core
  import seq_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prog_we,
  input  logic [ADDR_W-1:0]   prog_addr,
  input  logic [INSTR_W-1:0]  prog_data,
  output logic [ADDR_W-1:0]   dbg_pc,
  output logic [INSTR_W-1:0]  dbg_instr,
  output logic                dbg_wr_en,
  output logic [IDX_W-1:0]    dbg_wr_idx,
  output logic [DATA_W-1:0]   dbg_wr_data
);

  logic [ADDR_W-1:0]          pc;
  logic [INSTR_W-1:0]         word;
  instr_t                     cur;
  logic [1:0][IDX_W-1:0]      rd_idx;
  logic [1:0][DATA_W-1:0]     rd_val;
  logic [DATA_W-1:0]          alu_res;
  logic                       alu_ok;
  logic                       wr_en;

  seq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .pc  (pc)
  );

  seq_imem #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (word)
  );

  assign cur       = instr_t'(word);
  assign rd_idx[0] = cur.src_a;
  assign rd_idx[1] = cur.src_b;

  seq_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_RD(2)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (cur.dst),
    .wdata (alu_res),
    .raddr (rd_idx),
    .rdata (rd_val)
  );

  seq_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (cur.op),
    .a      (rd_val[0]),
    .b      (rd_val[1]),
    .result (alu_res),
    .valid  (alu_ok)
  );

  assign wr_en = alu_ok & ~rst;

  assign dbg_pc      = pc;
  assign dbg_instr   = word;
  assign dbg_wr_en   = wr_en;
  assign dbg_wr_idx  = cur.dst;
  assign dbg_wr_data = alu_res;

endmodule

// File: rtl/seq_alu_core_chk.sv
module seq_alu_core_chk
  import seq_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  pc,
  input logic [INSTR_W-1:0] instr,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  opnd_a
);

  instr_t dec;
  assign dec = instr_t'(instr);

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc == '0));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R10
  no_write_in_reset_chk: assert property (@(posedge clk) rst |-> !wr_en);

  // R8
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (dec.op > 4'b1000) |-> !wr_en);

  // R2
  dest_field_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx == instr[2:0]));

  // R7
  mov_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (dec.op == OP_MOV) |-> (wr_en && wr_data == opnd_a));

endmodule

bind seq_alu_core seq_alu_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (dbg_pc),
  .instr   (dbg_instr),
  .wr_en   (dbg_wr_en),
  .wr_idx  (dbg_wr_idx),
  .wr_data (dbg_wr_data),
  .opnd_a  (rd_val[0])
);

// File: tb/seq_alu_core_test.sv
`timescale 1ns/1ps
module seq_alu_core_test;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int IW     = 13;

  typedef struct {
    logic [ADDR_W-1:0] pc;
    logic [IW-1:0]     instr;
    logic              we;
    logic [2:0]        idx;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_we = 1'b0;
  logic [ADDR_W-1:0] prog_addr = '0;
  logic [IW-1:0] prog_data = '0;
  logic [ADDR_W-1:0] dbg_pc;
  logic [IW-1:0] dbg_instr;
  logic dbg_wr_en;
  logic [2:0] dbg_wr_idx;
  logic [DATA_W-1:0] dbg_wr_data;

  int n_checks = 0;
  int n_err = 0;
  logic running = 1'b0;
  exp_t sb[$];

  logic [IW-1:0] img [DEPTH];
  logic [DATA_W-1:0] m_rf [8];
  logic [ADDR_W-1:0] m_pc;
  logic [31:0] seed = 32'h1bad_5eed;

  always #5 clk = ~clk;

  seq_alu_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dbg_pc(dbg_pc), .dbg_instr(dbg_instr),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Field order: src_b, src_a, op, dst (R2)
  function automatic logic [IW-1:0] mk(logic [3:0] op, logic [2:0] a, logic [2:0] b, logic [2:0] d);
    return {b, a, op, d};
  endfunction

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic string req_of(logic [3:0] op);
    if (op == 4'd0 || op == 4'd1 || op == 4'd7 || op == 4'd8) return "R5";
    if (op >= 4'd2 && op <= 4'd5) return "R6";
    if (op == 4'd6) return "R7";
    return "R8";
  endfunction

  // Reference model of one instruction, written from the requirements.
  task automatic model_step();
    exp_t e;
    logic [IW-1:0] w;
    logic [DATA_W-1:0] a, b;
    w = img[m_pc];
    a = m_rf[w[9:7]];
    b = m_rf[w[12:10]];
    e.pc = m_pc; e.instr = w; e.idx = w[2:0]; e.we = 1'b1; e.data = '0;
    e.req = req_of(w[6:3]);
    case (w[6:3])
      4'd0: e.data = a + b;
      4'd1: e.data = a - b;
      4'd2: e.data = a & b;
      4'd3: e.data = a | b;
      4'd4: e.data = a ^ b;
      4'd5: e.data = ~a;
      4'd6: e.data = a;
      4'd7: e.data = a + 8'd1;
      4'd8: e.data = a - 8'd1;
      default: e.we = 1'b0;
    endcase
    if (e.we) m_rf[e.idx] = e.data;
    m_pc = m_pc + 1'b1;
    sb.push_back(e);
  endtask

  task automatic drive_run(int n);
    for (int i = 0; i < n; i++) model_step();
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_pc = '0;
  endtask

  task automatic load(logic [ADDR_W-1:0] addr, logic [IW-1:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = addr; prog_data = w;
    img[addr] = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  // Monitor: pops one expected item per cycle and compares it.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (running && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check("R3 R4", "pc", 32'(dbg_pc), 32'(e.pc));
        check("R2 R3", "instr", 32'(dbg_instr), 32'(e.instr));
        check(e.req, "wr_en", 32'(dbg_wr_en), 32'(e.we));
        if (e.we) begin
          check("R2", "wr_idx", 32'(dbg_wr_idx), 32'(e.idx));
          check({"R9 ", e.req}, "wr_data", 32'(dbg_wr_data), 32'(e.data));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [IW-1:0] dir [17];
    dir[0]  = mk(4'd0, 3'd5, 3'd6, 3'd0); // add from cleared regs -> 0 (R1)
    dir[1]  = mk(4'd7, 3'd1, 3'd7, 3'd1); // inc, srcB=7 (R11)
    dir[2]  = mk(4'd7, 3'd1, 3'd0, 3'd1); // inc, srcB=0 (R11)
    dir[3]  = mk(4'd7, 3'd1, 3'd3, 3'd1); // inc, srcB=3 (R11)
    dir[4]  = mk(4'd8, 3'd2, 3'd4, 3'd2); // dec 0 -> FF (R5)
    dir[5]  = mk(4'd0, 3'd2, 3'd1, 3'd3); // FF+3 -> 02 (R5, R9)
    dir[6]  = mk(4'd1, 3'd3, 3'd1, 3'd4); // 2-3 -> FF (R5)
    dir[7]  = mk(4'd2, 3'd4, 3'd1, 3'd5); // and (R6)
    dir[8]  = mk(4'd3, 3'd3, 3'd5, 3'd6); // or (R6)
    dir[9]  = mk(4'd4, 3'd4, 3'd1, 3'd7); // xor (R6)
    dir[10] = mk(4'd5, 3'd1, 3'd5, 3'd0); // not (R6, R11)
    dir[11] = mk(4'd6, 3'd7, 3'd2, 3'd6); // mov (R7)
    dir[12] = mk(4'd9, 3'd1, 3'd1, 3'd6); // unused code (R8)
    dir[13] = mk(4'hF, 3'd2, 3'd3, 3'd6); // unused code (R8)
    dir[14] = mk(4'd6, 3'd6, 3'd0, 3'd5); // read back r6 after unused codes (R8)
    dir[15] = mk(4'd7, 3'd7, 3'd1, 3'd7); // inc self (R9)
    dir[16] = mk(4'd8, 3'd1, 3'd6, 3'd0); // dec (R5)

    // R10: load the program while reset holds the core.
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] r;
      r = next_rand();
      if (i < 17) load(ADDR_W'(i), dir[i]);
      else        load(ADDR_W'(i), r[IW-1:0]);
    end

    // R1 / R10: reset state.
    @(negedge clk); #1;
    check("R1", "pc in reset", 32'(dbg_pc), 32'd0);
    check("R10", "wr_en in reset", 32'(dbg_wr_en), 32'd0);
    check("R3", "instr at 0", 32'(dbg_instr), 32'(img[0]));

    // Phase 1: run past the end of the store (R4).
    model_reset();
    drive_run(DEPTH + 24);
    @(negedge clk);
    rst = 1'b0; running = 1'b1;
    wait (sb.size() == 0);

    // Phase 2: reset mid-run, rewrite a word, then run again.
    @(negedge clk);
    running = 1'b0; rst = 1'b1;
    load(ADDR_W'(1), mk(4'd6, 3'd3, 3'd0, 3'd2)); // mov reads a cleared reg (R1, R10)
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R10", "pc held in reset", 32'(dbg_pc), 32'd0);
      check("R10", "wr_en in reset", 32'(dbg_wr_en), 32'd0);
    end
    model_reset();
    drive_run(24);
    @(negedge clk);
    rst = 1'b0; running = 1'b1;
    wait (sb.size() == 0);
    @(negedge clk);
    running = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule